// File: doc/BRIEF.md
# Multi-format pixel bus unpacker

This block sits between the serial port of a video frame memory and the colour path of a display pipeline. It takes 64-bit memory words and hands out one pixel per clock in a single internal form. That form is either an 8-bit palette index, for pseudo-colour, or three 8-bit colour components plus an 8-bit overlay field, for direct and true colour. Components narrower than 8 bits are widened by copying their top bits into the vacant low bits.

The format and the pixel order within a word are sampled from the configuration inputs only on a line-start pulse, so a format can be changed at any time and takes effect on the next line. The block fetches words by itself with a single-cycle request strobe. The memory side answers every request with a word in the following cycle. The block requests early enough that pixels flow without a gap, including in the packed 24-bit format, where pixels lie back to back and cross word boundaries.

Top module: `pixel_unpacker`

## Requirements
- R1: Out of reset, and until the first line-start pulse, `word_req` and `pix_valid` stay low whatever the other inputs do.
- R2: `cfg_fmt` and `cfg_big` are sampled only in a cycle with `line_start` high. A change at any other time does not affect the format or order of the pixels that follow in the current line.
- R3: Let `line_start` be high in cycle L. The first pixel appears on the outputs in cycle L+4, and `pix_valid` then stays high every cycle until the next line start. No pixel is taken from the buffer in a line-start cycle, and any bits still held from the previous line are dropped.
- R4: Let w be the pixel size in bits. In a cycle c after a line start, other than the line-start cycle itself, `word_req` is high exactly when the following value is less than 2w: 64 times the number of words accepted in the line, including one arriving in c, minus w times the number of pixels taken from the buffer through c. The word answering a request is read from `word_data` in the next cycle.
- R5: The words of a line form one bit stream. With `cfg_big`=0 the stream runs from bit 0 to bit 63 of each word in turn, and a pixel's first stream bit is its least significant bit. With `cfg_big`=1 it runs from bit 63 down to bit 0, and a pixel's first stream bit is its most significant bit.
- R6: `cfg_fmt` 0 (4-bit) and 1 (8-bit) are palette-index formats: `pix_index` is the pixel zero-extended, and overlay and colour outputs are 0.
- R7: `cfg_fmt` 2 is a 16-bit format: red in bits 15:11, green in 10:5, blue in 4:0, overlay 0.
- R8: `cfg_fmt` 3 is a 16-bit format: one overlay bit at bit 15 (output as 0 or 1), red in 14:10, green in 9:5, blue in 4:0.
- R9: `cfg_fmt` 4 is a 16-bit format: red in bits 15:10 (6 bits), green in 9:4 (6 bits), blue in 3:0 (4 bits), overlay 0.
- R10: `cfg_fmt` 5 is a 16-bit format: 4-bit overlay in bits 15:12 (zero-extended), red in 11:8, green in 7:4, blue in 3:0.
- R11: `cfg_fmt` 6 is a 32-bit format: overlay in bits 31:24, red in 23:16, green in 15:8, blue in 7:0.
- R12: `cfg_fmt` 7 is packed 24-bit: red in bits 23:16, green in 15:8 and blue in 7:0 of each 24-bit pixel, with no padding. Three words yield eight pixels, and a pixel crossing a word boundary completes from the next word.
- R13: A colour component of n<8 bits is widened to 8 bits as the n bits followed by its top 8-n bits. In index formats the colour outputs are 0, and in colour formats `pix_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse opening a new line; samples the configuration |
| cfg_fmt | input | 3 | Pixel format code, 0 to 7 |
| cfg_big | input | 1 | 1 selects most-significant-first pixel order |
| word_data | input | 64 | Memory word, valid in the cycle after a request |
| word_req | output | 1 | Request for the next memory word |
| pix_valid | output | 1 | A pixel is present on the pixel outputs |
| pix_index | output | 8 | Palette index (index formats) |
| pix_ovl | output | 8 | Overlay field |
| pix_r | output | 8 | Red component, widened |
| pix_g | output | 8 | Green component, widened |
| pix_b | output | 8 | Blue component, widened |

## Verification
Every result has a fixed due cycle. A request is combinational in the cycle its fill condition holds, and its word is read one cycle later. A pixel taken from the buffer in cycle c shows on the outputs in c+1. After a line start in cycle L, the first pixel is therefore due in L+4. The bench keeps its own bit count per line, using integer word and pixel counts. From that count it predicts the request bit every cycle and samples it shortly after the inputs settle at the falling edge. It predicts the pixel for output cycle c from the emission in c-1, decoding the stored words bit by bit. Each line also changes the configuration part way through to show that the change waits for the next line.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int PIX_MAX = 32;
    localparam int PBITS_W = 6;

    typedef enum logic [2:0] {
        FMT_IDX4     = 3'd0,
        FMT_IDX8     = 3'd1,
        FMT_RGB565   = 3'd2,
        FMT_ORGB1555 = 3'd3,
        FMT_RGB664   = 3'd4,
        FMT_ORGB4444 = 3'd5,
        FMT_ORGB8888 = 3'd6,
        FMT_RGB888P  = 3'd7
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic big;
    } mode_t;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] ovl;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } pix_t;

    function automatic logic [PBITS_W-1:0] bits_of(fmt_e f);
        case (f)
            FMT_IDX4:     return 6'd4;
            FMT_IDX8:     return 6'd8;
            FMT_ORGB8888: return 6'd32;
            FMT_RGB888P:  return 6'd24;
            default:      return 6'd16;
        endcase
    endfunction

    function automatic logic [7:0] grow4(logic [3:0] x);
        return {x, x};
    endfunction

    function automatic logic [7:0] grow5(logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    function automatic logic [7:0] grow6(logic [5:0] x);
        return {x, x[5:4]};
    endfunction

endpackage

// File: rtl/pxu_bitbuf.sv
module pxu_bitbuf #(
    parameter int WORD_W  = 64,
    parameter int RAW_W   = 32,
    parameter int PBITS_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               run,
    input  logic               big,
    input  logic [PBITS_W-1:0] pix_bits,
    input  logic [WORD_W-1:0]  word_data,
    output logic               word_req,
    output logic               emit,
    output logic [RAW_W-1:0]   raw
);
    localparam int BUF_W = 2 * WORD_W;
    localparam int CNT_W = $clog2(BUF_W + 1);
    localparam logic [RAW_W:0]       ONE_M    = {{RAW_W{1'b0}}, 1'b1};
    localparam logic [PBITS_W-1:0]   RAW_BITS = PBITS_W'(RAW_W);
    localparam logic [CNT_W-1:0]     WORD_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0]     BUF_CNT  = CNT_W'(BUF_W);

    logic [BUF_W-1:0] buf_q, buf_d, kept, fresh;
    logic [CNT_W-1:0] cnt_q, cnt_d, need, used, fill;
    logic             pend_q;
    logic [RAW_W:0]   mask;

    assign need = CNT_W'(pix_bits);
    assign emit = run && !clear && (cnt_q >= need);
    assign used = emit ? need : '0;
    assign fill = cnt_q - used;

    // Shift out the consumed pixel and place an arriving word after the kept bits.
    always_comb begin
        if (big) begin
            kept  = buf_q << used;
            fresh = {word_data, {WORD_W{1'b0}}} >> fill;
        end else begin
            kept  = buf_q >> used;
            fresh = {{WORD_W{1'b0}}, word_data} << fill;
        end
        buf_d = pend_q ? (kept | fresh) : kept;
        cnt_d = pend_q ? (fill + WORD_CNT) : fill;
    end

    // Ask for a word when fewer than two pixels would remain after this cycle.
    assign word_req = run && !clear && ({1'b0, cnt_d} < {need, 1'b0});

    assign mask = (ONE_M << pix_bits) - ONE_M;

    always_comb begin
        if (big) raw = buf_q[BUF_W-1 -: RAW_W] >> (RAW_BITS - pix_bits);
        else     raw = buf_q[RAW_W-1:0] & mask[RAW_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            buf_q  <= buf_d;
            cnt_q  <= cnt_d;
            pend_q <= word_req;
        end
    end

    p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
        word_req |=> !word_req);

    p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= BUF_CNT);

    p_word_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (word_req && !clear) |=> (clear || (cnt_d >= WORD_CNT)));

endmodule

// File: rtl/pxu_decode.sv
module pxu_decode
    import pxu_pkg::*;
(
    input  fmt_e              fmt,
    input  logic [PIX_MAX-1:0] raw,
    output pix_t              px
);
    always_comb begin
        px = '0;
        case (fmt)
            FMT_IDX4: px.idx = {4'h0, raw[3:0]};
            FMT_IDX8: px.idx = raw[7:0];
            FMT_RGB565: begin
                px.r = grow5(raw[15:11]);
                px.g = grow6(raw[10:5]);
                px.b = grow5(raw[4:0]);
            end
            FMT_ORGB1555: begin
                px.ovl = {7'd0, raw[15]};
                px.r   = grow5(raw[14:10]);
                px.g   = grow5(raw[9:5]);
                px.b   = grow5(raw[4:0]);
            end
            FMT_RGB664: begin
                px.r = grow6(raw[15:10]);
                px.g = grow6(raw[9:4]);
                px.b = grow4(raw[3:0]);
            end
            FMT_ORGB4444: begin
                px.ovl = {4'h0, raw[15:12]};
                px.r   = grow4(raw[11:8]);
                px.g   = grow4(raw[7:4]);
                px.b   = grow4(raw[3:0]);
            end
            FMT_ORGB8888: begin
                px.ovl = raw[31:24];
                px.r   = raw[23:16];
                px.g   = raw[15:8];
                px.b   = raw[7:0];
            end
            default: begin
                px.r = raw[23:16];
                px.g = raw[15:8];
                px.b = raw[7:0];
            end
        endcase
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [2:0]        cfg_fmt,
    input  logic              cfg_big,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_req,
    output logic              pix_valid,
    output logic [7:0]        pix_index,
    output logic [7:0]        pix_ovl,
    output logic [7:0]        pix_r,
    output logic [7:0]        pix_g,
    output logic [7:0]        pix_b
);
    mode_t              mode_q;
    logic               run_q;
    logic               emit;
    logic [PIX_MAX-1:0] raw;
    logic [PBITS_W-1:0] pbits;
    pix_t               pix_d, pix_q;
    logic               pv_q;

    assign pbits = bits_of(mode_q.fmt);

    // Configuration is taken only when a line opens.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{fmt: FMT_IDX4, big: 1'b0};
            run_q  <= 1'b0;
        end else if (line_start) begin
            mode_q <= '{fmt: fmt_e'(cfg_fmt), big: cfg_big};
            run_q  <= 1'b1;
        end
    end

    pxu_bitbuf #(
        .WORD_W (WORD_W),
        .RAW_W  (PIX_MAX),
        .PBITS_W(PBITS_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear    (line_start),
        .run      (run_q),
        .big      (mode_q.big),
        .pix_bits (pbits),
        .word_data(word_data),
        .word_req (word_req),
        .emit     (emit),
        .raw      (raw)
    );

    pxu_decode u_dec (
        .fmt(mode_q.fmt),
        .raw(raw),
        .px (pix_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q  <= 1'b0;
            pix_q <= '0;
        end else begin
            pv_q <= emit;
            if (emit) pix_q <= pix_d;
        end
    end

    assign pix_valid = pv_q;
    assign pix_index = pix_q.idx;
    assign pix_ovl   = pix_q.ovl;
    assign pix_r     = pix_q.r;
    assign pix_g     = pix_q.g;
    assign pix_b     = pix_q.b;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (!word_req && !pix_valid));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(line_start) |-> $stable(mode_q));

    p_stream_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_start) |=> pix_valid);

    p_index_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && (mode_q.fmt == FMT_IDX4 || mode_q.fmt == FMT_IDX8))
        |-> ({pix_ovl, pix_r, pix_g, pix_b} == 32'd0));

    p_idx4_range_r6: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mode_q.fmt == FMT_IDX4) |-> (pix_index[7:4] == 4'h0));

endmodule

// File: tb/test_pixel_unpacker.sv
module test_pixel_unpacker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic        cfg_big = 1'b0;
    logic [63:0] word_data = 64'd0;
    logic        word_req;
    logic        pix_valid;
    logic [7:0]  pix_index, pix_ovl, pix_r, pix_g, pix_b;

    always #10 clk = ~clk;

    pixel_unpacker #(.WORD_W(64)) i_pixel_unpacker (
        .clk(clk), .rst(rst), .line_start(line_start),
        .cfg_fmt(cfg_fmt), .cfg_big(cfg_big), .word_data(word_data),
        .word_req(word_req), .pix_valid(pix_valid), .pix_index(pix_index),
        .pix_ovl(pix_ovl), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ls_cyc = -1;
    int m_fmt = 0;
    bit m_big = 1'b0;
    bit req_prev = 1'b0;
    logic [63:0] line_words[$];

    function automatic int width_of(int f);
        case (f)
            0: return 4;
            1: return 8;
            6: return 32;
            7: return 24;
            default: return 16;
        endcase
    endfunction

    function automatic string tag_of(int f);
        case (f)
            0, 1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R9";
            5: return "R10";
            6: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [7:0] w5(int x); return 8'(((x & 31) << 3) | ((x & 31) >> 2)); endfunction
    function automatic logic [7:0] w6(int x); return 8'(((x & 63) << 2) | ((x & 63) >> 4)); endfunction
    function automatic logic [7:0] w4(int x); return 8'((x & 15) * 17); endfunction

    // Expected {index, overlay, r, g, b} for pixel k of the current line.
    function automatic logic [39:0] model_pix(int k, output bit miss);
        int w;
        longint raw;
        logic [7:0] ix, ov, r, g, b;
        w = width_of(m_fmt);
        raw = 0;
        miss = 1'b0;
        for (int i = 0; i < w; i++) begin
            int j;
            int wi;
            bit v;
            j = k * w + i;
            wi = j / 64;
            if (wi >= line_words.size()) begin
                miss = 1'b1;
                v = 1'b0;
            end else if (m_big) v = line_words[wi][63 - (j % 64)];
            else v = line_words[wi][j % 64];
            if (m_big) raw = raw | (longint'(v) << (w - 1 - i));
            else       raw = raw | (longint'(v) << i);
        end
        ix = 0; ov = 0; r = 0; g = 0; b = 0;
        case (m_fmt)
            0: ix = 8'(raw & 15);
            1: ix = 8'(raw & 255);
            2: begin r = w5(int'(raw >> 11)); g = w6(int'(raw >> 5)); b = w5(int'(raw)); end
            3: begin ov = 8'((raw >> 15) & 1); r = w5(int'(raw >> 10)); g = w5(int'(raw >> 5)); b = w5(int'(raw)); end
            4: begin r = w6(int'(raw >> 10)); g = w6(int'(raw >> 4)); b = w4(int'(raw)); end
            5: begin ov = 8'((raw >> 12) & 15); r = w4(int'(raw >> 8)); g = w4(int'(raw >> 4)); b = w4(int'(raw)); end
            6: begin ov = 8'(raw >> 24); r = 8'(raw >> 16); g = 8'(raw >> 8); b = 8'(raw); end
            default: begin r = 8'(raw >> 16); g = 8'(raw >> 8); b = 8'(raw); end
        endcase
        return {ix, ov, r, g, b};
    endfunction

    task automatic check_outputs();
        bit exp_v;
        int k;
        bit miss;
        logic [39:0] exp_p, got_p;
        exp_v = (ls_cyc >= 0) && (cyc - 1 >= ls_cyc + 3);
        checks++;
        if (pix_valid !== exp_v) begin
            failures++;
            $display("FAIL %s pix_valid cycle %0d got %0b exp %0b",
                     (ls_cyc < 0) ? "R1" : "R3", cyc, pix_valid, exp_v);
        end
        if (exp_v && pix_valid === 1'b1) begin
            k = cyc - 1 - (ls_cyc + 3);
            exp_p = model_pix(k, miss);
            got_p = {pix_index, pix_ovl, pix_r, pix_g, pix_b};
            checks++;
            if (miss || got_p !== exp_p) begin
                failures++;
                $display("FAIL %s R2 R5 R13 fmt %0d big %0b pixel %0d got %h exp %h",
                         tag_of(m_fmt), m_fmt, m_big, k, got_p, exp_p);
            end
        end
    endtask

    task automatic cycle(input bit ls, input int f, input bit bg);
        bit exp_r;
        int w;
        int taken;
        int avail;
        @(negedge clk);
        check_outputs();
        line_start = ls;
        cfg_fmt = 3'(f);
        cfg_big = bg;
        word_data = {$urandom, $urandom};
        if (ls) begin
            ls_cyc = cyc;
            m_fmt = f;
            m_big = bg;
            line_words.delete();
        end else if (req_prev && ls_cyc >= 0) begin
            line_words.push_back(word_data);
        end
        #1;
        if (ls || ls_cyc < 0) exp_r = 1'b0;
        else begin
            w = width_of(m_fmt);
            taken = (cyc >= ls_cyc + 3) ? (cyc - ls_cyc - 2) : 0;
            avail = line_words.size() * 64 - taken * w;
            exp_r = (avail < 2 * w);
        end
        checks++;
        if (word_req !== exp_r) begin
            failures++;
            $display("FAIL %s word_req cycle %0d got %0b exp %0b",
                     (ls_cyc < 0) ? "R1" : "R4", cyc, word_req, exp_r);
        end
        req_prev = (word_req === 1'b1);
        cyc++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle with changing inputs before any line opens
        for (int i = 0; i < 6; i++) cycle(1'b0, i, i[0]);
        for (int n = 0; n < 16; n++) begin
            int f;
            bit bg;
            int len;
            f = n % 8;
            bg = (n >= 8);
            len = 24 + n;
            cycle(1'b1, f, bg);
            for (int c = 0; c < len; c++) begin
                // R2: configuration changes mid-line must wait for the next line
                if (c < 9) cycle(1'b0, f, bg);
                else cycle(1'b0, f ^ 5, !bg);
            end
        end
        // back-to-back line starts
        cycle(1'b1, 7, 1'b0);
        cycle(1'b1, 2, 1'b1);
        for (int c = 0; c < 30; c++) cycle(1'b0, 0, 1'b0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired at cycle %0d got running exp finished", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule